// File: doc/BRIEF.md
# Exact-Ratio Tone Phase Generator

This block turns a fast reference clock into a slow periodic tone with no long-term frequency error. Instead of a binary phase accumulator, whose step can only approximate the wanted ratio, it steps a phase register by a small integer and wraps it at an arbitrary integer modulus. The output frequency is therefore exactly `STEP / MODULUS` of the clock rate. With the default `MODULUS = 500000` and `STEP = 3`, a 10 MHz reference gives exactly 60 output periods in every 10,000,000 clocks.

Four things come out: the current phase, a 50 % square wave, a one-clock pulse at the start of each output period, and a coarse phase index meant to address an external waveform table. A parameter picks between two internal forms. One is the step-by-`STEP` accumulator. The other is a down counter that steps by one and reloads at zero, from which the accumulator-equivalent phase is rebuilt. Both forms drive the ports identically, cycle for cycle.

Top module: `exact_tone_synth`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `phase_o` = 0, `wrap_o` = 0, `square_o` = 0 and `sine_idx_o` = 0.
- R2: On each clock edge with `en` high and `rst` low, `phase_o` becomes (`phase_o` + `STEP`) mod `MODULUS`.
- R3: `phase_o` is always below `MODULUS`.
- R4: On a clock edge with `en` low, `phase_o` keeps its value and `wrap_o` is 0 in the following cycle.
- R5: `wrap_o` is 1 for exactly the cycle after an enabled edge on which `phase_o` + `STEP` reached `MODULUS` or more, and is 0 otherwise. After N enabled clocks from reset, the pulse count is therefore floor(N·`STEP`/`MODULUS`), which is 60 per 10,000,000 clocks at the defaults.
- R6: `square_o` is 1 exactly when `phase_o` ≥ floor(`MODULUS`/2).
- R7: `sine_idx_o` equals floor(`phase_o`·2^`IDX_W`/`MODULUS`), so it stays within 0 to 2^`IDX_W`−1.
- R8: With `FORM = TONE_COUNTDOWN`, an internal counter starts at `MODULUS`−1, decrements by one on each enabled clock and reloads `MODULUS`−1 after 0. All ports match the `TONE_ACCUM` form on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; phase holds while low |
| phase_o | output | PW = $clog2(MODULUS) | Accumulator-equivalent phase, 0 to MODULUS−1 |
| square_o | output | 1 | 50 % duty square wave at the output frequency |
| wrap_o | output | 1 | One-clock pulse marking each output period |
| sine_idx_o | output | IDX_W | Coarse phase index for an external table |

## Verification
The bench runs a plain integer model of the modular step beside four instances: both forms at the default ratio, and both forms at a small ratio (1000 and 7) that wraps hundreds of times. The model is compared on every clock. The rollover cycle is the sharpest corner. An off-by-one in the wrap comparison would skip or double a value there, and a subtract of the wrong size would push the phase to `MODULUS` or beyond. Either fault would show up as a phase or pulse mismatch at once, and as a wrong total pulse count at the end.

Enable-low bursts check that a design advancing or pulsing while idle departs from the model. The square threshold and the index boundary values are compared at every phase the run reaches. The countdown form's reload-at-zero step is checked through its port equality with the accumulator form.

// File: rtl/tone_pkg.sv
package tone_pkg;

   // Internal realization of the modular phase generator.
   typedef enum logic {
      TONE_ACCUM     = 1'b0,   // add STEP each clock, wrap at MODULUS
      TONE_COUNTDOWN = 1'b1    // step-by-one down counter, phase rebuilt
   } tone_form_e;

endpackage

// File: rtl/tone_phase_accum.sv
module tone_phase_accum #(
   parameter int MODULUS = 500000,
   parameter int STEP    = 3,
   parameter int PW      = $clog2(MODULUS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [PW-1:0] phase_o
);

   localparam logic [PW:0] MOD_V  = (PW+1)'(MODULUS);
   localparam logic [PW:0] STEP_V = (PW+1)'(STEP);
   localparam logic [PW:0] LIMIT  = (PW+1)'(MODULUS - STEP);

   logic [PW-1:0] phase_q;
   logic [PW:0]   sum;
   logic [PW:0]   nxt;

   always_comb begin
      sum = {1'b0, phase_q} + STEP_V;
      if (sum >= MOD_V) nxt = sum - MOD_V;
      else              nxt = sum;
   end

   always_ff @(posedge clk) begin
      if (rst)     phase_q <= '0;
      else if (en) phase_q <= nxt[PW-1:0];
   end

   assign phase_o = phase_q;

   p_below_modulus_r3: assert property (@(posedge clk) disable iff (rst)
      {1'b0, phase_q} < MOD_V);

   p_advance_r2: assert property (@(posedge clk) disable iff (rst)
      (en && ({1'b0, phase_q} < LIMIT)) |=>
         ({1'b0, phase_q} == $past({1'b0, phase_q}) + STEP_V));

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase_q));

endmodule

// File: rtl/tone_phase_countdown.sv
module tone_phase_countdown #(
   parameter int MODULUS = 500000,
   parameter int STEP    = 3,
   parameter int PW      = $clog2(MODULUS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [PW-1:0] phase_o
);

   localparam int          TW     = PW + $clog2(STEP + 1);
   localparam logic [PW-1:0] TOP  = PW'(MODULUS - 1);
   localparam logic [TW-1:0] MOD_T = TW'(MODULUS);
   localparam logic [TW-1:0] STEP_T = TW'(STEP);

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] ord;     // step-by-one table address, counting up
   logic [TW-1:0] scaled;
   logic [TW-1:0] folded;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= TOP;
      else if (en) begin
         if (cnt_q == '0)     cnt_q <= TOP;
         else                 cnt_q <= cnt_q - 1'b1;
      end
   end

   // Rebuild the accumulator phase: (STEP * ord) mod MODULUS.
   // STEP*ord < STEP*MODULUS, so at most STEP-1 subtractions are needed;
   // the largest fitting multiple is selected by a comparison chain.
   always_comb begin
      ord    = TOP - cnt_q;
      scaled = TW'(ord) * STEP_T;
      folded = scaled;
      for (int k = 1; k < STEP; k++) begin
         if (scaled >= TW'(k) * MOD_T) folded = scaled - TW'(k) * MOD_T;
      end
   end

   assign phase_o = folded[PW-1:0];

   p_reload_r8: assert property (@(posedge clk) disable iff (rst)
      (en && cnt_q == '0) |=> (cnt_q == TOP));

   p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
      (en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_fold_range_r3: assert property (@(posedge clk) disable iff (rst)
      folded < MOD_T);

endmodule

// File: rtl/tone_wrap_detect.sv
module tone_wrap_detect #(
   parameter int MODULUS = 500000,
   parameter int STEP    = 3,
   parameter int PW      = $clog2(MODULUS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [PW-1:0] phase_i,
   output logic          wrap_o
);

   localparam logic [PW-1:0] EDGE = PW'(MODULUS - STEP);
   localparam logic [PW-1:0] STEP_P = PW'(STEP);

   logic wrap_q;

   always_ff @(posedge clk) begin
      if (rst) wrap_q <= 1'b0;
      else     wrap_q <= en && (phase_i >= EDGE);
   end

   assign wrap_o = wrap_q;

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      wrap_q |=> !wrap_q);

   p_pulse_after_rollover_r5: assert property (@(posedge clk) disable iff (rst)
      wrap_q |-> (phase_i < STEP_P));

endmodule

// File: rtl/tone_coarse_index.sv
module tone_coarse_index #(
   parameter int MODULUS = 500000,
   parameter int PW      = $clog2(MODULUS),
   parameter int IDX_W   = 8
) (
   input  logic [PW-1:0]    phase_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam int            XW    = PW + IDX_W + 1;
   localparam logic [XW-1:0] MOD_X = XW'(MODULUS);

   logic [XW-1:0]    lhs;
   logic [IDX_W-1:0] acc;
   logic [IDX_W-1:0] cand;

   // Successive approximation of floor(phase * 2^IDX_W / MODULUS):
   // a bit is kept when phase * 2^IDX_W >= candidate * MODULUS.
   always_comb begin
      lhs = XW'(phase_i) << IDX_W;
      acc = '0;
      for (int b = IDX_W - 1; b >= 0; b--) begin
         cand = acc | (IDX_W'(1) << b);
         if (lhs >= XW'(cand) * MOD_X) acc = cand;
      end
   end

   assign idx_o = acc;

endmodule

// File: rtl/exact_tone_synth.sv
module exact_tone_synth
   import tone_pkg::*;
#(
   parameter int         MODULUS = 500000,
   parameter int         STEP    = 3,
   parameter int         IDX_W   = 8,
   parameter tone_form_e FORM    = TONE_ACCUM,
   parameter int         PW      = $clog2(MODULUS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [PW-1:0]    phase_o,
   output logic             square_o,
   output logic             wrap_o,
   output logic [IDX_W-1:0] sine_idx_o
);

   localparam logic [PW-1:0] HALF = PW'(MODULUS / 2);

   // Elaboration-time parameter checks.
   if (MODULUS < 4) begin : g_bad_modulus
      $error("exact_tone_synth: MODULUS must be at least 4");
   end
   if (STEP < 1 || 2 * STEP > MODULUS) begin : g_bad_step
      $error("exact_tone_synth: STEP must lie in 1..MODULUS/2");
   end
   if (STEP > 16) begin : g_big_step
      $error("exact_tone_synth: STEP above 16 makes the fold chain too deep");
   end
   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("exact_tone_synth: IDX_W must lie in 1..16");
   end
   if ((1 << PW) < MODULUS) begin : g_bad_pw
      $error("exact_tone_synth: PW too narrow for MODULUS");
   end

   logic [PW-1:0] phase;

   if (FORM == TONE_COUNTDOWN) begin : g_countdown
      tone_phase_countdown #(
         .MODULUS (MODULUS),
         .STEP    (STEP),
         .PW      (PW)
      ) u_phase (
         .clk     (clk),
         .rst     (rst),
         .en      (en),
         .phase_o (phase)
      );
   end else begin : g_accum
      tone_phase_accum #(
         .MODULUS (MODULUS),
         .STEP    (STEP),
         .PW      (PW)
      ) u_phase (
         .clk     (clk),
         .rst     (rst),
         .en      (en),
         .phase_o (phase)
      );
   end

   tone_wrap_detect #(
      .MODULUS (MODULUS),
      .STEP    (STEP),
      .PW      (PW)
   ) u_wrap (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .phase_i (phase),
      .wrap_o  (wrap_o)
   );

   tone_coarse_index #(
      .MODULUS (MODULUS),
      .PW      (PW),
      .IDX_W   (IDX_W)
   ) u_index (
      .phase_i (phase),
      .idx_o   (sine_idx_o)
   );

   assign phase_o  = phase;
   assign square_o = (phase >= HALF);

   p_square_tracks_index_r6: assert property (@(posedge clk) disable iff (rst)
      (sine_idx_o >= IDX_W'(1 << (IDX_W - 1))) |-> square_o);

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (phase_o == '0 && !wrap_o));

endmodule

// File: tb/exact_tone_synth_bench.sv
`timescale 1ns/1ps
module exact_tone_synth_bench;
   import tone_pkg::*;

   localparam int ND = 4;
   localparam int M0 = 500000, S0 = 3, I0 = 8;
   localparam int M1 = 1000,   S1 = 7, I1 = 4;

   int mods [ND] = '{M0, M0, M1, M1};
   int steps[ND] = '{S0, S0, S1, S1};
   int idxw [ND] = '{I0, I0, I1, I1};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [18:0] p0, p1;
   logic [9:0]  p2, p3;
   logic [7:0]  x0, x1;
   logic [3:0]  x2, x3;
   logic        q0, q1, q2, q3, w0, w1, w2, w3;

   exact_tone_synth #(.MODULUS(M0), .STEP(S0), .IDX_W(I0), .FORM(TONE_ACCUM)) u_exact_tone_synth (
      .clk(clk), .rst(rst), .en(en), .phase_o(p0), .square_o(q0), .wrap_o(w0), .sine_idx_o(x0));
   exact_tone_synth #(.MODULUS(M0), .STEP(S0), .IDX_W(I0), .FORM(TONE_COUNTDOWN)) u_exact_tone_synth_cd (
      .clk(clk), .rst(rst), .en(en), .phase_o(p1), .square_o(q1), .wrap_o(w1), .sine_idx_o(x1));
   exact_tone_synth #(.MODULUS(M1), .STEP(S1), .IDX_W(I1), .FORM(TONE_ACCUM)) u_exact_tone_synth_sm (
      .clk(clk), .rst(rst), .en(en), .phase_o(p2), .square_o(q2), .wrap_o(w2), .sine_idx_o(x2));
   exact_tone_synth #(.MODULUS(M1), .STEP(S1), .IDX_W(I1), .FORM(TONE_COUNTDOWN)) u_exact_tone_synth_smcd (
      .clk(clk), .rst(rst), .en(en), .phase_o(p3), .square_o(q3), .wrap_o(w3), .sine_idx_o(x3));

   longint ph[ND], ix[ND];
   logic   sq[ND], wr[ND];
   always_comb begin
      ph[0] = longint'(p0); ph[1] = longint'(p1); ph[2] = longint'(p2); ph[3] = longint'(p3);
      ix[0] = longint'(x0); ix[1] = longint'(x1); ix[2] = longint'(x2); ix[3] = longint'(x3);
      sq[0] = q0; sq[1] = q1; sq[2] = q2; sq[3] = q3;
      wr[0] = w0; wr[1] = w1; wr[2] = w2; wr[3] = w3;
   end

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference, updated at each rising edge.
   longint mp[ND];
   bit     mw[ND];
   longint wcount_dut[ND], wcount_ref[ND];
   longint nen = 0;
   bit     live = 1'b0;

   always @(posedge clk) begin
      for (int d = 0; d < ND; d++) begin
         if (rst) begin
            mp[d] = 0; mw[d] = 1'b0; wcount_dut[d] = 0; wcount_ref[d] = 0;
         end else if (en) begin
            mw[d] = (mp[d] + steps[d] >= mods[d]);
            mp[d] = (mp[d] + steps[d]) % mods[d];
         end else begin
            mw[d] = 1'b0;
         end
      end
      if (rst) nen = 0;
      else if (en) nen++;
      #2;
      if (live) begin
         for (int d = 0; d < ND; d++) begin
            longint eidx;
            eidx = (mp[d] * (64'sd1 <<< idxw[d])) / mods[d];
            check(ph[d] == mp[d], "R2", $sformatf("phase dut%0d", d), ph[d], mp[d]);
            check(ph[d] < mods[d], "R3", $sformatf("phase range dut%0d", d), ph[d], mods[d] - 1);
            check(wr[d] == mw[d], "R5", $sformatf("wrap dut%0d", d), longint'(wr[d]), longint'(mw[d]));
            check(sq[d] == (mp[d] >= mods[d] / 2), "R6", $sformatf("square dut%0d", d),
                  longint'(sq[d]), longint'(mp[d] >= mods[d] / 2));
            check(ix[d] == eidx, "R7", $sformatf("index dut%0d", d), ix[d], eidx);
            if (wr[d]) wcount_dut[d]++;
            if (mw[d]) wcount_ref[d]++;
         end
         // R8: countdown form equals accumulator form at the ports.
         check(p1 == p0 && q1 == q0 && w1 == w0 && x1 == x0, "R8", "countdown vs accum default",
               longint'(p1), longint'(p0));
         check(p3 == p2 && q3 == q2 && w3 == w2 && x3 == x2, "R8", "countdown vs accum small",
               longint'(p3), longint'(p2));
      end
   end

   task automatic check_reset_state(input string tag);
      for (int d = 0; d < ND; d++) begin
         check(ph[d] == 0, "R1", {tag, " phase"}, ph[d], 0);
         check(wr[d] == 1'b0, "R1", {tag, " wrap"}, longint'(wr[d]), 0);
         check(sq[d] == 1'b0, "R1", {tag, " square"}, longint'(sq[d]), 0);
         check(ix[d] == 0, "R1", {tag, " index"}, ix[d], 0);
      end
   endtask

   initial begin
      longint held;
      repeat (3) @(negedge clk);
      check_reset_state("reset");
      live = 1'b1;
      rst  = 1'b0;
      // Long run with short enable-low bursts (R4 probes).
      for (int i = 0; i < 170000; i++) begin
         @(negedge clk);
         if (i % 5000 == 4997) held = ph[2];
         if (i % 5000 == 4999) begin
            // R4: after two idle edges the small-ratio phase is unchanged and no pulse.
            check(ph[2] == held, "R4", "hold while disabled", ph[2], held);
            check(w2 == 1'b0, "R4", "no pulse while disabled", longint'(w2), 0);
         end
         en = !(i % 5000 >= 4997);
      end
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      // R5: pulse totals follow floor(N*STEP/MODULUS).
      for (int d = 0; d < ND; d++) begin
         longint exp_w;
         exp_w = (nen * steps[d]) / mods[d];
         check(wcount_dut[d] == exp_w, "R5", $sformatf("pulse total dut%0d", d), wcount_dut[d], exp_w);
         check(wcount_ref[d] == exp_w, "R5", $sformatf("model total dut%0d", d), wcount_ref[d], exp_w);
      end
      // R1: reset in mid-run with nonzero phase.
      en  = 1'b1;
      rst = 1'b1;
      live = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_reset_state("mid-run reset");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule